// File: doc/BRIEF.md
# Transmit/Receive Holding Register Status Tracker

This block keeps the four status flags that describe the handshake between a one-word transmit holding register, a one-word receive holding register and the serial shifter sitting between them. It does not move data. It watches strobes from the register interface (a transmit write, a receive read, a status read), strobes and levels from the shifter (word taken for transmit, word delivered on receive, shifter idle), and enable and disable commands. From these it produces a four-bit status word.

The status word has four flags. The transmit-register-empty flag tells software that it may write another word. The transmit-path-empty flag tells software that everything it wrote has left the shifter. It also waits out a programmable guard delay after the shifter goes idle, so that back-to-back frames keep a minimum gap. The receive-full flag marks an unread word. The overrun flag records that a received word was overwritten before software read it.

A programmable down-counter times the guard delay. The counter reloads each time the shifter goes idle. A new transmit write, a shifter restart or a disable command abandons the count.

Top module: `hs_xfer_status`

## Requirements
- R1: After reset all four status bits are 0. The status word is laid out as bit 3 overrun, bit 2 transmit path empty, bit 1 transmit register empty, bit 0 receive full.
- R2: While disabled, both transmit flags read 0. An enable command given while disabled sets both to 1 at the next edge. An enable command given while already enabled has no effect.
- R3: While enabled, a transmit write clears both transmit flags at the next edge.
- R4: While enabled, a shifter-load strobe without a transmit write in the same cycle sets the transmit-register-empty flag. With a transmit write in the same cycle, the flag stays 0.
- R5: With the holding register empty and delay value D, the transmit-path-empty flag rises D+1 cycles after the edge that first samples the shifter idle high. A transmit write during that count abandons it.
- R6: A fall of shifter idle during the count abandons the count. The next rise of shifter idle restarts the count from the delay value then configured.
- R7: While enabled, a receive load sets the receive-full flag, and a receive read alone clears it. When a load and a read occur in the same cycle, the flag ends at 1.
- R8: While enabled, overrun sets on a receive load that finds receive-full already 1 with no receive read in the same cycle. A status read clears overrun, except that a new overrun in the same cycle wins.
- R9: A disable command clears all four flags and stops the delay counter. While the block is disabled, transmit writes, shifter strobes, receive loads and reads leave every flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_cmd | input | 1 | One-cycle enable command |
| disable_cmd | input | 1 | One-cycle disable command, wins over enable |
| tx_write | input | 1 | Software wrote the transmit holding register |
| shift_load | input | 1 | Shifter took the transmit holding word |
| shift_idle | input | 1 | Shifter has no word in progress (level) |
| rx_load | input | 1 | Shifter wrote a word into the receive holding register |
| rx_read | input | 1 | Software read the receive holding register |
| status_read | input | 1 | Software read the status word |
| delay_cfg | input | DLY_W | Guard delay in cycles after the shifter goes idle |
| status | output | 4 | {overrun, tx path empty, tx register empty, rx full} |

## Verification
The bench first runs directed sequences. One is a single word written, loaded and shifted out under delays of 0 and 3. Another lets shifter idle glitch low mid-count, so that a restart can be told apart from a continued count. A third places a write in mid-count, which separates a cancel from a late set. The receive sequences cover double loads, a load coinciding with a read and a load coinciding with a status read; these separate the clear-versus-set priority of the receive flags. Disable is issued in mid-count and followed by re-enable, which shows whether the disable truly clears. After the directed part, a long stretch of random strobes with random delays is compared on every clock against a behavioural model, to reach orderings the directed part does not.

// File: rtl/hs_status_pkg.sv
package hs_status_pkg;
    // Status word bit positions; software decodes these.
    localparam int ST_RXFULL = 0;
    localparam int ST_TXREG  = 1;
    localparam int ST_TXALL  = 2;
    localparam int ST_OVR    = 3;
    localparam int ST_W      = 4;

    typedef struct packed {
        logic txreg;
        logic txall;
    } tx_flags_t;

    typedef struct packed {
        logic full;
        logic ovr;
    } rx_flags_t;
endpackage

// File: rtl/hs_guard_timer.sv
module hs_guard_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cancel,
    input  logic             idle,
    input  logic [DLY_W-1:0] delay,
    output logic             done
);
    typedef struct packed {
        logic             armed;
        logic [DLY_W-1:0] cnt;
        logic             idle_prev;
    } tmr_t;

    tmr_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        s_d.idle_prev = idle;
        if (!run) begin
            s_d.armed = 1'b0;
            s_d.cnt   = '0;
        end else if (cancel || !idle) begin
            s_d.armed = 1'b0;
        end else if (idle && !s_q.idle_prev) begin
            s_d.armed = 1'b1;
            s_d.cnt   = delay;
        end else if (s_q.armed && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (s_q.armed) begin
            s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{armed: 1'b0, cnt: '0, idle_prev: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.armed && (s_q.cnt == '0);

    // R6: a shifter that is busy never leaves the count running
    a_r6_busy_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !idle) |=> !s_q.armed);
    // R9: a stopped block holds no pending count
    a_r9_stop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !s_q.armed);
endmodule

// File: rtl/hs_tx_flags.sv
module hs_tx_flags
    import hs_status_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      dis,
    input  logic      en_pulse,
    input  logic      wr,
    input  logic      load,
    input  logic      idle,
    input  logic      tmr_done,
    output tx_flags_t flags
);
    tx_flags_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (dis || (!en && !en_pulse)) begin
            f_d = '0;
        end else if (!en) begin
            f_d.txreg = 1'b1;
            f_d.txall = 1'b1;
        end else begin
            if (wr)        f_d.txreg = 1'b0;
            else if (load) f_d.txreg = 1'b1;
            if (wr)                                  f_d.txall = 1'b0;
            else if (tmr_done && idle && f_q.txreg)  f_d.txall = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q;

    // R3: an accepted write empties neither flag
    a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr) |=> (!f_q.txreg && !f_q.txall));
    // R4: shifter taking the word frees the holding register
    a_r4_load_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dis && load && !wr) |=> f_q.txreg);
    // R5: the whole path is never empty while the holding register is full
    a_r5_all_implies_reg: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.txall |-> f_q.txreg);
endmodule

// File: rtl/hs_rx_flags.sv
module hs_rx_flags
    import hs_status_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      ld,
    input  logic      rd,
    input  logic      srd,
    output rx_flags_t flags
);
    rx_flags_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (!run) begin
            f_d = '0;
        end else begin
            if (ld)      f_d.full = 1'b1;
            else if (rd) f_d.full = 1'b0;
            if (ld && f_q.full && !rd) f_d.ovr = 1'b1;
            else if (srd)              f_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q;

    // R7: a read with no new load empties the receive register
    a_r7_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ld) |=> !f_q.full);
    // R8: second load without a read is recorded
    a_r8_second_load: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ld && f_q.full && !rd) |=> f_q.ovr);
endmodule

// File: rtl/hs_xfer_status.sv
module hs_xfer_status
    import hs_status_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_cmd,
    input  logic             disable_cmd,
    input  logic             tx_write,
    input  logic             shift_load,
    input  logic             shift_idle,
    input  logic             rx_load,
    input  logic             rx_read,
    input  logic             status_read,
    input  logic [DLY_W-1:0] delay_cfg,
    output logic [ST_W-1:0]  status
);
    logic      en_q, en_d;
    logic      en_pulse;
    logic      run;
    logic      tmr_done;
    tx_flags_t txf;
    rx_flags_t rxf;

    always_comb begin
        en_d = en_q;
        if (disable_cmd)     en_d = 1'b0;
        else if (enable_cmd) en_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en_pulse = enable_cmd && !en_q && !disable_cmd;
    assign run      = en_q && !disable_cmd;

    hs_guard_timer #(.DLY_W(DLY_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .cancel (tx_write),
        .idle   (shift_idle),
        .delay  (delay_cfg),
        .done   (tmr_done)
    );

    hs_tx_flags u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .dis      (disable_cmd),
        .en_pulse (en_pulse),
        .wr       (tx_write),
        .load     (shift_load),
        .idle     (shift_idle),
        .tmr_done (tmr_done),
        .flags    (txf)
    );

    hs_rx_flags u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ld    (rx_load),
        .rd    (rx_read),
        .srd   (status_read),
        .flags (rxf)
    );

    always_comb begin
        status = '0;
        status[ST_RXFULL] = rxf.full;
        status[ST_TXREG]  = txf.txreg;
        status[ST_TXALL]  = txf.txall;
        status[ST_OVR]    = rxf.ovr;
    end

    // R9: a disabled block reports nothing
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (status == '0));
    // R2: enabling from the disabled state presents both transmit flags
    a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        en_pulse |=> (status[ST_TXREG] && status[ST_TXALL]));
endmodule

// File: tb/hs_xfer_status_bench.sv
module hs_xfer_status_bench;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ena = 0, dis = 0, wr = 0, sl = 0, idle = 1, rl = 0, rr = 0, sr = 0;
    logic [DW-1:0] dly = '0;
    logic [3:0] status;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hs_xfer_status #(.DLY_W(DW)) u_hs_xfer_status (
        .clk(clk), .rst_n(rst_n), .enable_cmd(ena), .disable_cmd(dis),
        .tx_write(wr), .shift_load(sl), .shift_idle(idle), .rx_load(rl),
        .rx_read(rr), .status_read(sr), .delay_cfg(dly), .status(status)
    );

    // Behavioural reference model
    int m_en, m_txreg, m_txall, m_rxf, m_ovr, m_armed, m_cnt, m_iprev;
    initial begin
        m_en = 0; m_txreg = 0; m_txall = 0; m_rxf = 0; m_ovr = 0;
        m_armed = 0; m_cnt = 0; m_iprev = 1;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_txreg = 0; m_txall = 0; m_rxf = 0; m_ovr = 0;
            m_armed = 0; m_cnt = 0; m_iprev = 1;
        end else begin
            int running, fin, n_txreg, n_txall, n_rxf, n_ovr;
            running = (m_en != 0) && !dis;
            fin = (m_armed != 0) && (m_cnt == 0);
            n_txreg = m_txreg; n_txall = m_txall;
            if (dis || (m_en == 0 && !ena)) begin
                n_txreg = 0; n_txall = 0;
            end else if (m_en == 0) begin
                n_txreg = 1; n_txall = 1;
            end else begin
                if (wr) n_txreg = 0; else if (sl) n_txreg = 1;
                if (wr) n_txall = 0;
                else if (fin && idle && m_txreg != 0) n_txall = 1;
            end
            n_rxf = m_rxf; n_ovr = m_ovr;
            if (!running) begin
                n_rxf = 0; n_ovr = 0;
            end else begin
                if (rl) n_rxf = 1; else if (rr) n_rxf = 0;
                if (rl && m_rxf != 0 && !rr) n_ovr = 1; else if (sr) n_ovr = 0;
            end
            if (!running) begin
                m_armed = 0; m_cnt = 0;
            end else if (wr || !idle) begin
                m_armed = 0;
            end else if (idle && m_iprev == 0) begin
                m_armed = 1; m_cnt = int'(dly);
            end else if (m_armed != 0 && m_cnt != 0) begin
                m_cnt = m_cnt - 1;
            end else begin
                m_armed = 0;
            end
            m_iprev = idle;
            if (dis) m_en = 0; else if (ena) m_en = 1;
            m_txreg = n_txreg; m_txall = n_txall; m_rxf = n_rxf; m_ovr = n_ovr;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_model();
        chk("R7 rx full bit0", int'(status[0]), m_rxf);
        chk("R4 tx reg empty bit1", int'(status[1]), m_txreg);
        chk("R5 tx path empty bit2", int'(status[2]), m_txall);
        chk("R8 overrun bit3", int'(status[3]), m_ovr);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        compare_model();
    endtask

    task automatic clr();
        ena = 0; dis = 0; wr = 0; sl = 0; rl = 0; rr = 0; sr = 0;
    endtask

    // Send one word and bring the shifter back to idle; returns cycles to tx path empty.
    task automatic send_word(input int d, output int n);
        dly = DW'(d);
        wr = 1; step(); clr();
        sl = 1; idle = 0; step(); clr();
        repeat (4) step();
        idle = 1;
        n = 0;
        for (int k = 0; k < 300; k++) begin
            step(); n++;
            if (status[2]) break;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 reset status", int'(status), 0);
        rst_n = 1;
        step();
        chk("R1 status after reset release", int'(status), 0);

        // R9: activity while disabled is ignored
        wr = 1; sl = 1; rl = 1; step(); clr();
        rl = 1; step(); clr();
        chk("R9 ignored while disabled", int'(status), 0);

        // R2: enable
        ena = 1; step(); clr();
        chk("R2 enable sets tx flags", int'(status), 4'b0110);
        ena = 1; step(); clr();
        chk("R2 re-enable no effect", int'(status), 4'b0110);

        // R3
        wr = 1; step(); clr();
        chk("R3 write clears tx flags", int'(status[2:1]), 0);
        // R4 load with write in same cycle keeps register busy
        wr = 1; sl = 1; idle = 0; step(); clr();
        chk("R4 load plus write keeps busy", int'(status[1]), 0);
        sl = 1; step(); clr();
        chk("R4 load frees holding register", int'(status[1]), 1);
        chk("R5 path not empty while busy", int'(status[2]), 0);
        repeat (3) step();
        dly = 8'd3; idle = 1;
        n = 0;
        for (int k = 0; k < 50; k++) begin step(); n++; if (status[2]) break; end
        chk("R5 delay 3 timing", n, 5);

        send_word(0, n);
        chk("R5 delay 0 timing", n, 2);

        // R6: idle glitch restarts count
        dly = 8'd5;
        wr = 1; step(); clr();
        sl = 1; idle = 0; step(); clr();
        step(); idle = 1; step(); step(); step();
        idle = 0; step();
        chk("R6 no set after glitch", int'(status[2]), 0);
        dly = 8'd2; idle = 1;
        n = 0;
        for (int k = 0; k < 50; k++) begin step(); n++; if (status[2]) break; end
        chk("R6 restart uses new delay", n, 4);

        // R5: write mid-count cancels
        dly = 8'd6;
        wr = 1; step(); clr();
        sl = 1; idle = 0; step(); clr();
        step(); idle = 1; step(); step();
        wr = 1; step(); clr();
        repeat (12) step();
        chk("R5 write cancels count", int'(status[2]), 0);
        sl = 1; idle = 0; step(); clr();
        chk("R4 second word taken", int'(status[1]), 1);

        // R7 / R8
        idle = 1;
        rl = 1; step(); clr();
        chk("R7 load sets full", int'(status[0]), 1);
        rl = 1; step(); clr();
        chk("R8 second load sets overrun", int'(status[3]), 1);
        sr = 1; step(); clr();
        chk("R8 status read clears overrun", int'(status[3]), 0);
        chk("R7 full survives status read", int'(status[0]), 1);
        rl = 1; rr = 1; step(); clr();
        chk("R7 load with read stays full", int'(status[0]), 1);
        chk("R8 load with read no overrun", int'(status[3]), 0);
        rl = 1; sr = 1; step(); clr();
        chk("R8 new overrun beats status read", int'(status[3]), 1);
        rr = 1; step(); clr();
        chk("R7 read clears full", int'(status[0]), 0);

        // R9: disable mid-count then re-enable
        dly = 8'd20;
        wr = 1; step(); clr();
        sl = 1; idle = 0; step(); clr();
        rl = 1; step(); clr(); rl = 1; step(); clr();
        idle = 1; step(); step();
        dis = 1; ena = 1; step(); clr();
        chk("R9 disable clears all", int'(status), 0);
        ena = 1; step(); clr();
        chk("R9 re-enable fresh tx flags", int'(status), 4'b0110);

        // Random phase against the model
        for (int k = 0; k < 4000; k++) begin
            ena = ($urandom_range(0, 60) == 0);
            dis = ($urandom_range(0, 90) == 0);
            wr  = ($urandom_range(0, 9) == 0);
            sl  = ($urandom_range(0, 7) == 0);
            rl  = ($urandom_range(0, 5) == 0);
            rr  = ($urandom_range(0, 5) == 0);
            sr  = ($urandom_range(0, 6) == 0);
            if ($urandom_range(0, 5) == 0) idle = ~idle;
            if ($urandom_range(0, 40) == 0) dly = DW'($urandom_range(0, 6));
            step();
        end
        clr();
        step();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule